// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block stores received frames into a circular buffer of 256-byte pages in local memory. The ring is bounded by a start page and a stop page. Software owns a boundary page, and the block owns a current page. Before a frame is offered, the block reports whether the ring has room for a maximum-size frame. A frame is taken with a one-cycle start pulse that carries its byte length.

The payload then arrives as a byte stream under a valid/ready handshake. Frames shorter than the minimum are padded with zero bytes. The data is laid down four bytes past the start of the current page. A write that reaches the stop page carries on at the start page.

When the data is finished, the block writes a four-byte header at the start of the frame's first page. It then moves the current page past the frame, rounded up to whole pages and with room left for a trailing CRC. Finally it raises a receive event that can drive a masked interrupt line.

Top module: `rxring_writer`

## Requirements
- R1: While `stopCmd` is high, `roomOk` is low and a `frmStart` pulse is ignored: no memory write happens, `inReady` stays low and `curPage` does not change.
- R2: Free space in bytes is 256*(boundary−current) when current < boundary. Otherwise it is 256*((stop−start)−(current−boundary)). `roomOk` is high only when this is at least 1518, and a `frmStart` while `roomOk` is low is ignored.
- R3: When the current page equals the boundary page, the ring counts as empty. `roomOk` is then high whenever the ring spans at least 1518 bytes.
- R4: Accepted payload byte k is written to address current*256 + 4 + k, one write per handshake (`inValid` and `inReady` both high). The memory write port is registered and appears one cycle after the transfer.
- R5: A frame of fewer than 60 bytes is followed by zero bytes up to a total of 60. The number of memory writes for a frame is max(len,60) + 4.
- R6: When a data address reaches stop*256, writing continues at start*256. No write falls outside [start*256, stop*256).
- R7: The header occupies bytes 0..3 of the frame's first page: 0x01 (good status), next page, low byte of L, high byte of L. Here L = max(len,60) + 4.
- R8: The next page is current + ceil((L+4)/256). If this reaches or passes the stop page, (stop−start) is subtracted from it. `curPage` takes this value when the frame completes and is otherwise changed only by `curLoad`.
- R9: `rxEvent` is set when a frame completes and cleared by `eventClr`. `irq` equals `rxEvent` AND `eventMask`.
- R10: `rxStatus` reads 0x00 after reset. After a completed frame it reads 0x01, the same value as the header's status byte.
- R11: After reset, `curPage`, `rxStatus`, `rxEvent`, `irq`, `memWe` and `inReady` are all zero.
- R12: `inReady` is high only while payload bytes are awaited. It is low during padding and header writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopCmd | input | 1 | Receiver held stopped; no frame accepted |
| ringStart | input | 8 | First page of the ring |
| ringStop | input | 8 | Page one past the last page of the ring |
| boundary | input | 8 | Software-owned boundary page |
| curLoad | input | 1 | Load `curLoadVal` into the current page |
| curLoadVal | input | 8 | Value for the current page |
| curPage | output | 8 | Current page, where the next frame begins |
| roomOk | output | 1 | Ring can hold a maximum-size frame |
| frmStart | input | 1 | One-cycle pulse offering a frame |
| frmLen | input | 11 | Frame length in bytes (1..1514) |
| inValid | input | 1 | Payload byte valid |
| inData | input | 8 | Payload byte |
| inReady | output | 1 | Block takes a payload byte this cycle |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory byte address |
| memData | output | 8 | Memory write data |
| rxStatus | output | 8 | Status byte of the last stored frame |
| eventClr | input | 1 | Clears the receive event |
| eventMask | input | 1 | Enables the receive event onto `irq` |
| rxEvent | output | 1 | Receive event flag |
| irq | output | 1 | Masked interrupt request |

## Verification
Frame lengths are chosen to separate the pad path from the plain path: 1, 59, 60 and 1514 bytes, plus random lengths. These show where padding starts and stops, and they exercise the high byte of the stored length.

Frames begun two and four pages before the stop page cover two wrap cases. In one, the data wraps. In the other, the next page lands exactly on the stop page and must fold back to the start page.

Boundary placements at five and six free pages, on either side of the current page, tell a correct free-space rule from an off-by-one rule. A boundary equal to the current page tells the empty-ring reading from the full-ring reading. Random payloads, with idle gaps in the valid signal, show whether every handshake writes exactly one byte at the right address.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_HDR
  } rxState_e;

  typedef struct packed {
    logic       latch;
    logic       wrData;
    logic       wrPad;
    logic       wrHdr;
    logic [1:0] hdrIdx;
    logic       commit;
  } rxStrb_t;
endpackage

// File: rtl/rxring_ctl.sv
module rxring_ctl
  import rxring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stopCmd,
  input  logic    frmStart,
  input  logic    roomOk,
  input  logic    inValid,
  input  logic    lastData,
  input  logic    needPad,
  input  logic    padDone,
  output rxStrb_t strb,
  output logic    inReady
);
  rxState_e   state, stateNxt;
  logic [1:0] hdrCnt;

  always_comb begin
    strb        = '0;
    strb.latch  = (state == ST_IDLE) && frmStart && roomOk;
    strb.wrData = (state == ST_DATA) && inValid;
    strb.wrPad  = (state == ST_PAD);
    strb.wrHdr  = (state == ST_HDR);
    strb.hdrIdx = hdrCnt;
    strb.commit = (state == ST_HDR) && (hdrCnt == 2'd3);
    inReady     = (state == ST_DATA);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (strb.latch) stateNxt = ST_DATA;
      ST_DATA: if (inValid && lastData) stateNxt = needPad ? ST_PAD : ST_HDR;
      ST_PAD:  if (padDone) stateNxt = ST_HDR;
      ST_HDR:  if (strb.commit) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_HDR) hdrCnt <= hdrCnt + 2'd1;
      else                 hdrCnt <= '0;
    end
  end

  // R1: a stopped receiver never leaves idle
  p_stop_blocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stopCmd) |=> (state == ST_IDLE));

  // R12: a handshake is never taken outside the data phase
  p_ready_data_only_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPad || strb.wrHdr) |-> !inReady);
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 11,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int CRC_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stopCmd,
  input  logic [PAGE_W-1:0]        ringStart,
  input  logic [PAGE_W-1:0]        ringStop,
  input  logic [PAGE_W-1:0]        boundary,
  input  logic                     curLoad,
  input  logic [PAGE_W-1:0]        curLoadVal,
  input  logic [LEN_W-1:0]         frmLen,
  input  logic [7:0]               inData,
  input  logic                     eventClr,
  input  rxStrb_t                  strb,
  output logic                     roomOk,
  output logic                     lastData,
  output logic                     needPad,
  output logic                     padDone,
  output logic [PAGE_W-1:0]        curPage,
  output logic                     memWe,
  output logic [PAGE_W+OFF_W-1:0]  memAddr,
  output logic [7:0]               memData,
  output logic [7:0]               rxStatus,
  output logic                     rxEvent
);
  localparam int ADDR_W     = PAGE_W + OFF_W;
  localparam int HDR_BYTES  = 4;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int SW         = ADDR_W + 2;
  localparam logic signed [SW-1:0] ROOM_NEED = SW'(MAX_FRAME + CRC_BYTES);
  localparam logic [7:0] GOOD_STATUS = 8'h01;

  logic [LEN_W-1:0]  lenQ, cnt, padded;
  logic [15:0]       stLenQ;
  logic [PAGE_W-1:0] nextPgQ, nextCalc;
  logic [ADDR_W-1:0] wrAddr, incAddr, wrapAddr;
  logic [LEN_W:0]    spanB;
  logic [PAGE_W:0]   spanPg, sumPg;
  logic signed [SW-1:0] curB, bndB, ringB, freeB;
  logic [7:0]        hdrByte;

  // free space in bytes, empty ring when current equals boundary
  always_comb begin
    curB  = SW'({curPage, {OFF_W{1'b0}}});
    bndB  = SW'({boundary, {OFF_W{1'b0}}});
    ringB = SW'({ringStop, {OFF_W{1'b0}}}) - SW'({ringStart, {OFF_W{1'b0}}});
    if (curPage < boundary) freeB = bndB - curB;
    else                    freeB = ringB - (curB - bndB);
    roomOk = !stopCmd && (freeB >= ROOM_NEED);
  end

  // frame geometry from the offered length
  always_comb begin
    padded   = (frmLen < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frmLen;
    spanB    = (LEN_W+1)'(padded) + (LEN_W+1)'(HDR_BYTES + CRC_BYTES + PAGE_BYTES - 1);
    spanPg   = (PAGE_W+1)'(spanB >> OFF_W);
    sumPg    = {1'b0, curPage} + spanPg;
    if (sumPg >= {1'b0, ringStop})
      nextCalc = PAGE_W'(sumPg - ({1'b0, ringStop} - {1'b0, ringStart}));
    else
      nextCalc = PAGE_W'(sumPg);
  end

  always_comb begin
    incAddr  = wrAddr + ADDR_W'(1);
    wrapAddr = (incAddr == {ringStop, {OFF_W{1'b0}}}) ? {ringStart, {OFF_W{1'b0}}} : incAddr;
    lastData = (cnt == lenQ - LEN_W'(1));
    needPad  = (lenQ < LEN_W'(MIN_FRAME));
    padDone  = (cnt == LEN_W'(MIN_FRAME - 1));
    unique case (strb.hdrIdx)
      2'd0:    hdrByte = GOOD_STATUS;
      2'd1:    hdrByte = 8'(nextPgQ);
      2'd2:    hdrByte = stLenQ[7:0];
      default: hdrByte = stLenQ[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      lenQ     <= '0;
      cnt      <= '0;
      stLenQ   <= '0;
      nextPgQ  <= '0;
      wrAddr   <= '0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      rxStatus <= '0;
      rxEvent  <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (strb.latch) begin
        lenQ    <= frmLen;
        cnt     <= '0;
        stLenQ  <= 16'(padded) + 16'(HDR_BYTES);
        nextPgQ <= nextCalc;
        wrAddr  <= {curPage, {OFF_W{1'b0}}} + ADDR_W'(HDR_BYTES);
      end
      if (strb.wrData || strb.wrPad) begin
        memWe   <= 1'b1;
        memAddr <= wrAddr;
        memData <= strb.wrData ? inData : 8'h00;
        wrAddr  <= wrapAddr;
        cnt     <= cnt + LEN_W'(1);
      end
      if (strb.wrHdr) begin
        memWe   <= 1'b1;
        memAddr <= {curPage, {OFF_W{1'b0}}} + ADDR_W'(strb.hdrIdx);
        memData <= hdrByte;
      end
      if (strb.commit) begin
        curPage  <= nextPgQ;
        rxStatus <= GOOD_STATUS;
      end else if (curLoad) begin
        curPage <= curLoadVal;
      end
      if (strb.commit)   rxEvent <= 1'b1;
      else if (eventClr) rxEvent <= 1'b0;
    end
  end

  // R5: padding cycles store zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPad |=> (memWe && memData == 8'h00));

  // R6: every write stays inside the ring
  p_in_ring_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr >= {ringStart, {OFF_W{1'b0}}} && memAddr < {ringStop, {OFF_W{1'b0}}}));

  // R8: current page moves only on completion or load
  p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !curLoad) |=> $stable(curPage));

  // R9: completion raises the event
  p_commit_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> rxEvent);

  // R10: completion records good status
  p_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (rxStatus == GOOD_STATUS));
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 11,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int CRC_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stopCmd,
  input  logic [PAGE_W-1:0]       ringStart,
  input  logic [PAGE_W-1:0]       ringStop,
  input  logic [PAGE_W-1:0]       boundary,
  input  logic                    curLoad,
  input  logic [PAGE_W-1:0]       curLoadVal,
  output logic [PAGE_W-1:0]       curPage,
  output logic                    roomOk,
  input  logic                    frmStart,
  input  logic [LEN_W-1:0]        frmLen,
  input  logic                    inValid,
  input  logic [7:0]              inData,
  output logic                    inReady,
  output logic                    memWe,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]              memData,
  output logic [7:0]              rxStatus,
  input  logic                    eventClr,
  input  logic                    eventMask,
  output logic                    rxEvent,
  output logic                    irq
);
  rxStrb_t strb;
  logic    lastData, needPad, padDone;

  rxring_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stopCmd(stopCmd), .frmStart(frmStart),
    .roomOk(roomOk), .inValid(inValid), .lastData(lastData),
    .needPad(needPad), .padDone(padDone), .strb(strb), .inReady(inReady)
  );

  rxring_dp #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME), .CRC_BYTES(CRC_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stopCmd(stopCmd), .ringStart(ringStart),
    .ringStop(ringStop), .boundary(boundary), .curLoad(curLoad),
    .curLoadVal(curLoadVal), .frmLen(frmLen), .inData(inData),
    .eventClr(eventClr), .strb(strb), .roomOk(roomOk), .lastData(lastData),
    .needPad(needPad), .padDone(padDone), .curPage(curPage), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .rxStatus(rxStatus), .rxEvent(rxEvent)
  );

  assign irq = rxEvent & eventMask;
endmodule

// File: tb/test_rxring_writer.sv
module test_rxring_writer;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        stopCmd = 1'b0, curLoad = 1'b0, frmStart = 1'b0, inValid = 1'b0;
  logic        eventClr = 1'b0, eventMask = 1'b0;
  logic [7:0]  ringStart = 8'h40, ringStop = 8'h60, boundary = 8'h40, curLoadVal = 8'h00;
  logic [10:0] frmLen = '0;
  logic [7:0]  inData = '0;
  logic [7:0]  curPage, memData, rxStatus;
  logic [15:0] memAddr;
  logic        roomOk, inReady, memWe, rxEvent, irq;

  rxring_writer i_rxring_writer (
    .clk(clk), .rstN(rstN), .stopCmd(stopCmd), .ringStart(ringStart),
    .ringStop(ringStop), .boundary(boundary), .curLoad(curLoad),
    .curLoadVal(curLoadVal), .curPage(curPage), .roomOk(roomOk),
    .frmStart(frmStart), .frmLen(frmLen), .inValid(inValid), .inData(inData),
    .inReady(inReady), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .rxStatus(rxStatus), .eventClr(eventClr), .eventMask(eventMask),
    .rxEvent(rxEvent), .irq(irq)
  );

  always #10 clk = ~clk;

  logic [7:0] shadow [0:65535];
  int wrCount = 0, outRing = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always @(posedge clk) if (memWe) begin
    shadow[memAddr] <= memData;
    wrCount <= wrCount + 1;
    if (memAddr < {ringStart, 8'h00} || memAddr >= {ringStop, 8'h00}) outRing <= outRing + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expNext(int cur, int len);
    int pad = (len < 60) ? 60 : len;
    int n = cur + (pad + 4 + 4 + 255) / 256;
    if (n >= ringStop) n -= (ringStop - ringStart);
    return n;
  endfunction

  function automatic int expAddr(int cur, int k);
    int a = cur * 256 + 4 + k;
    if (a >= ringStop * 256) a -= (ringStop - ringStart) * 256;
    return a;
  endfunction

  task automatic setCur(input int p);
    curLoadVal = 8'(p); curLoad = 1'b1;
    @(negedge clk);
    curLoad = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    bit r;
    inValid = 1'b1; inData = b;
    do begin
      r = inReady;
      @(negedge clk);
    end while (!r);
    inValid = 1'b0;
  endtask

  task automatic runFrame(input int len, input bit msk, input bit gaps);
    logic [7:0] data [];
    int cur, pad, nxt, bad, badPad, w0, stLen, waitN;
    cur = curPage; pad = (len < 60) ? 60 : len; stLen = pad + 4;
    nxt = expNext(cur, len);
    data = new[len];
    foreach (data[i]) data[i] = 8'($urandom);
    eventMask = msk; w0 = wrCount;
    frmLen = 11'(len); frmStart = 1'b1;
    @(negedge clk);
    frmStart = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      sendByte(data[k]);
    end
    bad = 0; waitN = 0;
    while (!rxEvent && waitN < 300) begin
      if (inReady) bad++;
      @(negedge clk); waitN++;
    end
    chk(bad == 0, "R12", "inReady high after payload", bad, 0);
    @(negedge clk);
    chk(shadow[cur*256] == 8'h01, "R7", "header status", shadow[cur*256], 1);
    chk(shadow[cur*256+1] == 8'(nxt), "R7", "header next page", shadow[cur*256+1], nxt);
    chk({shadow[cur*256+3], shadow[cur*256+2]} == 16'(stLen), "R7", "header length",
        {shadow[cur*256+3], shadow[cur*256+2]}, stLen);
    bad = 0;
    for (int k = 0; k < len; k++) if (shadow[expAddr(cur, k)] != data[k]) bad++;
    chk(bad == 0, "R4", "payload byte mismatches", bad, 0);
    badPad = 0;
    for (int k = len; k < pad; k++) if (shadow[expAddr(cur, k)] != 8'h00) badPad++;
    chk(badPad == 0, "R5", "nonzero pad bytes", badPad, 0);
    chk(wrCount - w0 == pad + 4, "R5", "write count", wrCount - w0, pad + 4);
    chk(curPage == 8'(nxt), "R8", "current page", curPage, nxt);
    chk(rxEvent == 1'b1, "R9", "event set", rxEvent, 1);
    chk(irq == msk, "R9", "irq vs mask", irq, msk);
    chk(rxStatus == 8'h01, "R10", "status", rxStatus, 1);
    eventClr = 1'b1;
    @(negedge clk);
    eventClr = 1'b0;
    chk(rxEvent == 1'b0 && irq == 1'b0, "R9", "event cleared", rxEvent, 0);
  endtask

  task automatic expectRefused(input string req);
    int w0 = wrCount, c0 = curPage;
    frmLen = 11'd100; frmStart = 1'b1;
    @(negedge clk);
    frmStart = 1'b0;
    repeat (4) begin
      chk(inReady == 1'b0, req, "inReady after refused start", inReady, 0);
      @(negedge clk);
    end
    chk(wrCount == w0 && curPage == 8'(c0), req, "writes after refused start", wrCount - w0, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(curPage == 0 && rxStatus == 0 && !rxEvent && !irq && !memWe && !inReady,
        "R11", "reset state", {curPage, rxStatus}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rxStatus == 8'h00, "R10", "status after reset", rxStatus, 0);
    setCur(8'h40); boundary = 8'h40;
    chk(roomOk == 1'b1, "R3", "empty ring has room", roomOk, 1);

    stopCmd = 1'b1; @(negedge clk);
    chk(roomOk == 1'b0, "R1", "roomOk while stopped", roomOk, 0);
    expectRefused("R1");
    stopCmd = 1'b0;

    boundary = 8'h45; @(negedge clk);
    chk(roomOk == 1'b0, "R2", "five pages ahead", roomOk, 0);
    expectRefused("R2");
    boundary = 8'h46; @(negedge clk);
    chk(roomOk == 1'b1, "R2", "six pages ahead", roomOk, 1);
    setCur(8'h50); boundary = 8'h4B; @(negedge clk);
    chk(roomOk == 1'b1, "R2", "27 pages behind", roomOk, 1);
    boundary = 8'h4F; @(negedge clk);
    chk(roomOk == 1'b1, "R2", "31 pages wrapped free", roomOk, 1);
    setCur(8'h5A); boundary = 8'h5F; @(negedge clk);
    chk(roomOk == 1'b0, "R2", "five pages free", roomOk, 0);
    boundary = 8'h5A; @(negedge clk);
    chk(roomOk == 1'b1, "R3", "current equals boundary", roomOk, 1);

    setCur(8'h40); boundary = 8'h40;
    runFrame(1, 1'b1, 1'b0);
    boundary = curPage; runFrame(59, 1'b0, 1'b1);
    boundary = curPage; runFrame(60, 1'b1, 1'b0);
    boundary = curPage; runFrame(1514, 1'b1, 1'b1);
    setCur(8'h5E); boundary = 8'h5E;
    runFrame(1000, 1'b1, 1'b0);
    chk(curPage == 8'h42, "R6", "page after data wrap", curPage, 8'h42);
    setCur(8'h5C); boundary = 8'h5C;
    runFrame(1000, 1'b0, 1'b0);
    chk(curPage == 8'h40, "R8", "next page folds at stop", curPage, 8'h40);

    for (int n = 0; n < 20; n++) begin
      boundary = curPage;
      runFrame(int'($urandom % 1514) + 1, 1'($urandom), 1'($urandom));
    end
    chk(outRing == 0, "R6", "writes outside ring", outRing, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule